// File: doc/BRIEF.md
# I2C Interrupt Flag and Vector Unit

This block keeps the two error flags of an I2C controller, no-acknowledge and arbitration-lost, and turns them into an interrupt request and a prioritised vector code. A separate bus engine, not part of this block, reports what happens on the wire as single-cycle strobes. These strobes cover an acknowledge sampled, a no-acknowledge sampled, arbitration lost and a start requested. The engine also supplies two levels: bus-busy, and a flag saying that a general-call transfer is in progress.

Software reaches the block through a small register port with four word addresses: mode, status, enable and vector. The mode register holds the controller's role as a four-state machine. `ROLE_SLV_RX`, `ROLE_SLV_TX`, `ROLE_MST_RX` and `ROLE_MST_TX` are encoded as {master, transmit}. The register also holds a stop request and a run bit. Two transitions move the role. The write transition loads the role that software writes. The arbitration-loss transition forces `ROLE_SLV_RX` and drops the stop request, and it overrides a write in the same cycle.

Each flag can be cleared by writing one to it, by reading the vector while the vector shows that flag, or by module reset (run written to 0). A no-acknowledge flag is also cleared by a later acknowledge.

Top module: `i2c_flag_vector`

## Requirements
- R1: After system reset, mode, status, enable and vector all read 0. The irq, master_o, xmit_o and stop_o outputs are 0.
- R2: The NACK flag (status bit 1) sets on a nack strobe only while the role is transmitting (mode bit 2 = 1). While receiving, the nack strobe is ignored.
- R3: An ack strobe while transmitting, with no general call in progress, clears the NACK flag.
- R4: An ack strobe while transmitting during a general call sets the NACK flag.
- R5: The ARB flag (status bit 0) sets on an arbitration-lost strobe only in the master-transmitter role (mode bits 3 and 2 both 1). In any other role the strobe is ignored.
- R6: A start strobe while bus_busy is 1 sets the ARB flag in any role. A start strobe with bus_busy at 0 has no effect on the flags.
- R7: At the edge where ARB sets, the role becomes slave-receiver and the stop bit (mode bit 1) clears. This happens even when a mode write arrives in the same cycle. The run bit (mode bit 0) still takes the written value.
- R8: Writing the status address clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R9: The vector (bits 2:0) reads 1 when ARB is set and enabled (enable bit 0). Otherwise it reads 2 when NACK is set and enabled (enable bit 1). Otherwise it reads 0. A disabled flag still sets but is not shown.
- R10: A read strobe at the vector address clears only the flag whose code the vector shows at that time.
- R11: irq is 1 exactly when at least one flag is both set and enabled.
- R12: While the run bit is 0, both flags read 0 and all events are ignored. Writing run = 0 clears both flags at that edge.
- R13: When a flag's set event and any clear of that flag fall in the same cycle, the flag ends up set. Module reset is the exception and still wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only at the vector address) |
| reg_addr | input | 2 | 0 mode, 1 status, 2 enable, 3 vector |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational from addr |
| ev_ack | input | 1 | Acknowledge sampled |
| ev_nack | input | 1 | No-acknowledge sampled |
| ev_arb_lost | input | 1 | Arbitration lost on the wire |
| ev_start_req | input | 1 | Start requested |
| bus_busy | input | 1 | Bus-busy level |
| gen_call | input | 1 | General-call transfer in progress |
| irq | output | 1 | Interrupt request |
| master_o | output | 1 | Master role bit |
| xmit_o | output | 1 | Transmit role bit |
| stop_o | output | 1 | Stop request bit |

## Verification
Flags, enables and the mode register change at the clock edge that samples the strobe or write. The vector, irq and read data follow combinationally from those registers, so all three are valid during the cycle after that edge. The bench applies each stimulus for exactly one cycle from a falling edge. At the next falling edge it returns all inputs to idle, then sweeps the address across mode, status and vector without a read strobe and compares each value. This leaves one full idle cycle between stimuli, so no check can see a half-applied event.

// File: rtl/i2cfv_pkg.sv
package i2cfv_pkg;
    localparam int MODE_RUN    = 0;
    localparam int MODE_STOP   = 1;
    localparam int MODE_XMIT   = 2;
    localparam int MODE_MASTER = 3;
    localparam int MODE_BITS   = 4;

    localparam int NFLAGS    = 2;
    localparam int FLAG_ARB  = 0;
    localparam int FLAG_NACK = 1;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_EN   = 2'd2;
    localparam logic [1:0] ADDR_VEC  = 2'd3;

    typedef enum logic [1:0] {
        ROLE_SLV_RX = 2'b00,
        ROLE_SLV_TX = 2'b01,
        ROLE_MST_RX = 2'b10,
        ROLE_MST_TX = 2'b11
    } role_e;

    typedef enum logic [2:0] {
        VEC_NONE = 3'd0,
        VEC_ARB  = 3'd1,
        VEC_NACK = 3'd2
    } vec_e;
endpackage

// File: rtl/i2cfv_role.sv
module i2cfv_role
    import i2cfv_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_we,
    input  logic [DW-1:0] wdata,
    input  logic          arb_set,
    output role_e         role_o,
    output logic          run_o,
    output logic          stop_o
);
    role_e state_q, state_d;
    role_e written;
    logic  run_q, run_d, stop_q, stop_d;
    logic  unused_hi;

    assign written   = role_e'({wdata[MODE_MASTER], wdata[MODE_XMIT]});
    assign unused_hi = ^wdata;

    // Transitions: T_ARB_LOSS beats T_WRITE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ROLE_MST_TX: begin
                if (arb_set)      state_d = ROLE_SLV_RX;
                else if (mode_we) state_d = written;
            end
            ROLE_MST_RX, ROLE_SLV_TX, ROLE_SLV_RX: begin
                if (arb_set)      state_d = ROLE_SLV_RX;
                else if (mode_we) state_d = written;
            end
            default: state_d = ROLE_SLV_RX;
        endcase
    end

    // Mode-bit outputs
    always_comb begin
        run_d  = mode_we ? wdata[MODE_RUN] : run_q;
        stop_d = stop_q;
        if (arb_set)      stop_d = 1'b0;
        else if (mode_we) stop_d = wdata[MODE_STOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ROLE_SLV_RX;
            run_q   <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            stop_q  <= stop_d;
        end
    end

    assign role_o = state_q;
    assign run_o  = run_q;
    assign stop_o = stop_q;
endmodule

// File: rtl/i2cfv_flags.sv
module i2cfv_flags
    import i2cfv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_q,
    input  logic              mode_we,
    input  logic              mode_run_bit,
    input  role_e             role,
    input  logic              ev_ack,
    input  logic              ev_nack,
    input  logic              ev_arb_lost,
    input  logic              ev_start_req,
    input  logic              bus_busy,
    input  logic              gen_call,
    input  logic              stat_we,
    input  logic [NFLAGS-1:0] stat_w1c,
    input  logic              vec_rd,
    input  vec_e              vec_code,
    output logic              arb_q,
    output logic              nack_q,
    output logic              arb_set_o
);
    logic mreset, active, is_tx;
    logic arb_set, arb_clr, nack_set, nack_clr;

    assign mreset = !run_q || (mode_we && !mode_run_bit);
    assign active = !mreset;
    assign is_tx  = (role == ROLE_SLV_TX) || (role == ROLE_MST_TX);

    assign arb_set  = active && ((ev_arb_lost && role == ROLE_MST_TX) ||
                                 (ev_start_req && bus_busy));
    assign nack_set = active && is_tx && (ev_nack || (ev_ack && gen_call));

    assign arb_clr  = (stat_we && stat_w1c[FLAG_ARB]) ||
                      (vec_rd && vec_code == VEC_ARB);
    assign nack_clr = (stat_we && stat_w1c[FLAG_NACK]) ||
                      (vec_rd && vec_code == VEC_NACK) ||
                      (is_tx && ev_ack && !gen_call);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q  <= 1'b0;
            nack_q <= 1'b0;
        end else if (mreset) begin
            arb_q  <= 1'b0;
            nack_q <= 1'b0;
        end else begin
            arb_q  <= arb_set  || (arb_q  && !arb_clr);
            nack_q <= nack_set || (nack_q && !nack_clr);
        end
    end

    assign arb_set_o = arb_set;

    p_nack_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_q) |-> $past(is_tx));
    p_arb_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        arb_set |=> arb_q);
    p_nack_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        nack_set |=> nack_q);
    p_vec_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && vec_code == VEC_ARB && !arb_set) |=> !arb_q);
endmodule

// File: rtl/i2cfv_vector.sv
module i2cfv_vector
    import i2cfv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic [NFLAGS-1:0] en_wdata,
    input  logic              arb_q,
    input  logic              nack_q,
    output logic [NFLAGS-1:0] en_o,
    output vec_e              code_o,
    output logic              irq_o
);
    logic [NFLAGS-1:0] en_q, flags, pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= en_wdata;
    end

    assign flags[FLAG_ARB]  = arb_q;
    assign flags[FLAG_NACK] = nack_q;

    for (genvar g = 0; g < NFLAGS; g++) begin : g_pend
        assign pend[g] = flags[g] & en_q[g];
    end

    always_comb begin
        if (pend[FLAG_ARB])       code_o = VEC_ARB;
        else if (pend[FLAG_NACK]) code_o = VEC_NACK;
        else                      code_o = VEC_NONE;
    end

    assign irq_o = |pend;
    assign en_o  = en_q;

    p_irq_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> code_o != VEC_NONE);
endmodule

// File: rtl/i2c_flag_vector.sv
module i2c_flag_vector
    import i2cfv_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          ev_ack,
    input  logic          ev_nack,
    input  logic          ev_arb_lost,
    input  logic          ev_start_req,
    input  logic          bus_busy,
    input  logic          gen_call,
    output logic          irq,
    output logic          master_o,
    output logic          xmit_o,
    output logic          stop_o
);
    role_e             role;
    vec_e              code;
    logic              run, stop, arb_q, nack_q, arb_set;
    logic              mode_we, stat_we, en_we, vec_rd;
    logic [NFLAGS-1:0] en;

    assign mode_we = reg_wr && reg_addr == ADDR_MODE;
    assign stat_we = reg_wr && reg_addr == ADDR_STAT;
    assign en_we   = reg_wr && reg_addr == ADDR_EN;
    assign vec_rd  = reg_rd && reg_addr == ADDR_VEC;

    i2cfv_role #(.DW(DW)) u_role (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .wdata(reg_wdata),
        .arb_set(arb_set), .role_o(role), .run_o(run), .stop_o(stop)
    );

    i2cfv_flags u_flags (
        .clk(clk), .rst_n(rst_n), .run_q(run), .mode_we(mode_we),
        .mode_run_bit(reg_wdata[MODE_RUN]), .role(role),
        .ev_ack(ev_ack), .ev_nack(ev_nack), .ev_arb_lost(ev_arb_lost),
        .ev_start_req(ev_start_req), .bus_busy(bus_busy), .gen_call(gen_call),
        .stat_we(stat_we), .stat_w1c(reg_wdata[NFLAGS-1:0]),
        .vec_rd(vec_rd), .vec_code(code),
        .arb_q(arb_q), .nack_q(nack_q), .arb_set_o(arb_set)
    );

    i2cfv_vector u_vector (
        .clk(clk), .rst_n(rst_n), .en_we(en_we),
        .en_wdata(reg_wdata[NFLAGS-1:0]), .arb_q(arb_q), .nack_q(nack_q),
        .en_o(en), .code_o(code), .irq_o(irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_MODE: begin
                reg_rdata[MODE_RUN]    = run;
                reg_rdata[MODE_STOP]   = stop;
                reg_rdata[MODE_XMIT]   = role[0];
                reg_rdata[MODE_MASTER] = role[1];
            end
            ADDR_STAT: begin
                reg_rdata[FLAG_ARB]  = arb_q;
                reg_rdata[FLAG_NACK] = nack_q;
            end
            ADDR_EN:  reg_rdata[NFLAGS-1:0] = en;
            ADDR_VEC: reg_rdata[2:0] = code;
            default:  reg_rdata = '0;
        endcase
    end

    assign master_o = role[1];
    assign xmit_o   = role[0];
    assign stop_o   = stop;

    p_arb_role_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_q) |-> (role == ROLE_SLV_RX && !stop));
    p_mreset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!arb_q && !nack_q));
endmodule

// File: tb/tb_i2c_flag_vector.sv
module tb_i2c_flag_vector;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int NROWS = 28;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [1:0] addr;
        logic [7:0] wdata;
        logic [3:0] ev;     // {ack, nack, arb_lost, start}
        logic       busy;
        logic       gcall;
        logic [3:0] emode;  // {master, xmit, stop, run}
        logic [1:0] estat;  // {nack, arb}
        logic [2:0] evec;
        logic       eirq;
        logic [3:0] req;
    } row_t;

    localparam row_t ROWS [NROWS] = '{
        '{1'b1,1'b0,2'd0,8'h05,4'b0000,1'b0,1'b0,4'h5,2'd0,3'd0,1'b0,4'd2},  // R2 prep: run, slave tx
        '{1'b0,1'b0,2'd0,8'h00,4'b0100,1'b0,1'b0,4'h5,2'd2,3'd0,1'b0,4'd9},  // R9 R2: set while disabled
        '{1'b1,1'b0,2'd2,8'h03,4'b0000,1'b0,1'b0,4'h5,2'd2,3'd2,1'b1,4'd11}, // R11 enable both
        '{1'b0,1'b0,2'd0,8'h00,4'b1000,1'b0,1'b0,4'h5,2'd0,3'd0,1'b0,4'd3},  // R3 ack clears
        '{1'b0,1'b0,2'd0,8'h00,4'b1000,1'b0,1'b1,4'h5,2'd2,3'd2,1'b1,4'd4},  // R4 general call
        '{1'b1,1'b0,2'd1,8'h01,4'b0000,1'b0,1'b0,4'h5,2'd2,3'd2,1'b1,4'd8},  // R8 zero bit keeps
        '{1'b1,1'b0,2'd1,8'h02,4'b0000,1'b0,1'b0,4'h5,2'd0,3'd0,1'b0,4'd8},  // R8 one bit clears
        '{1'b1,1'b0,2'd0,8'h01,4'b0000,1'b0,1'b0,4'h1,2'd0,3'd0,1'b0,4'd2},  // slave rx
        '{1'b0,1'b0,2'd0,8'h00,4'b0100,1'b0,1'b0,4'h1,2'd0,3'd0,1'b0,4'd2},  // R2 nack ignored in rx
        '{1'b0,1'b0,2'd0,8'h00,4'b0010,1'b0,1'b0,4'h1,2'd0,3'd0,1'b0,4'd5},  // R5 arb ignored
        '{1'b1,1'b0,2'd0,8'h0F,4'b0000,1'b0,1'b0,4'hF,2'd0,3'd0,1'b0,4'd5},  // master tx + stop
        '{1'b0,1'b0,2'd0,8'h00,4'b0100,1'b0,1'b0,4'hF,2'd2,3'd2,1'b1,4'd2},  // R2 master nack
        '{1'b0,1'b0,2'd0,8'h00,4'b0010,1'b0,1'b0,4'h1,2'd3,3'd1,1'b1,4'd7},  // R7 R5 R9 arb lost
        '{1'b0,1'b1,2'd3,8'h00,4'b0000,1'b0,1'b0,4'h1,2'd2,3'd2,1'b1,4'd10}, // R10 clears arb only
        '{1'b0,1'b1,2'd3,8'h00,4'b0000,1'b0,1'b0,4'h1,2'd0,3'd0,1'b0,4'd10}, // R10 clears nack
        '{1'b0,1'b0,2'd0,8'h00,4'b0001,1'b1,1'b0,4'h1,2'd1,3'd1,1'b1,4'd6},  // R6 start while busy
        '{1'b1,1'b0,2'd1,8'h01,4'b0000,1'b0,1'b0,4'h1,2'd0,3'd0,1'b0,4'd8},  // clear arb
        '{1'b0,1'b0,2'd0,8'h00,4'b0001,1'b0,1'b0,4'h1,2'd0,3'd0,1'b0,4'd6},  // R6 idle bus: none
        '{1'b1,1'b0,2'd1,8'h01,4'b0001,1'b1,1'b0,4'h1,2'd1,3'd1,1'b1,4'd13}, // R13 set beats w1c
        '{1'b1,1'b0,2'd0,8'h0F,4'b0001,1'b1,1'b0,4'h1,2'd1,3'd1,1'b1,4'd7},  // R7 beats mode write
        '{1'b1,1'b0,2'd2,8'h02,4'b0000,1'b0,1'b0,4'h1,2'd1,3'd0,1'b0,4'd9},  // R9 arb disabled
        '{1'b1,1'b0,2'd0,8'h05,4'b0000,1'b0,1'b0,4'h5,2'd1,3'd0,1'b0,4'd11}, // slave tx
        '{1'b0,1'b0,2'd0,8'h00,4'b0100,1'b0,1'b0,4'h5,2'd3,3'd2,1'b1,4'd9},  // R9 nack shown
        '{1'b1,1'b0,2'd0,8'h04,4'b0000,1'b0,1'b0,4'h4,2'd0,3'd0,1'b0,4'd12}, // R12 run off clears
        '{1'b0,1'b0,2'd0,8'h00,4'b0100,1'b0,1'b0,4'h4,2'd0,3'd0,1'b0,4'd12}, // R12 event ignored
        '{1'b1,1'b0,2'd0,8'h05,4'b0000,1'b0,1'b0,4'h5,2'd0,3'd0,1'b0,4'd12}, // run on
        '{1'b0,1'b0,2'd0,8'h00,4'b0100,1'b0,1'b0,4'h5,2'd2,3'd2,1'b1,4'd2},  // nack
        '{1'b0,1'b1,2'd3,8'h00,4'b0100,1'b0,1'b0,4'h5,2'd2,3'd2,1'b1,4'd13}  // R13 set beats vec read
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr, reg_rd;
    logic [1:0]    reg_addr;
    logic [DW-1:0] reg_wdata, reg_rdata;
    logic          ev_ack, ev_nack, ev_arb_lost, ev_start_req, bus_busy, gen_call;
    logic          irq, master_o, xmit_o, stop_o;
    int            checks = 0;
    int            errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_flag_vector #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_ack(ev_ack), .ev_nack(ev_nack), .ev_arb_lost(ev_arb_lost),
        .ev_start_req(ev_start_req), .bus_busy(bus_busy), .gen_call(gen_call),
        .irq(irq), .master_o(master_o), .xmit_o(xmit_o), .stop_o(stop_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 0; reg_rd = 0; reg_addr = 2'd0; reg_wdata = '0;
        ev_ack = 0; ev_nack = 0; ev_arb_lost = 0; ev_start_req = 0;
        bus_busy = 0; gen_call = 0;
    endtask

    // peek registers without a read strobe, so no side effect
    task automatic peek_all(input string tag, input int emode, input int estat,
                            input int evec, input int eirq);
        reg_addr = 2'd0; #1;
        chk({tag, " mode"}, int'(reg_rdata), emode);
        chk({tag, " pins"}, int'({master_o, xmit_o, stop_o}), emode >> 1);
        reg_addr = 2'd1; #1;
        chk({tag, " status"}, int'(reg_rdata), estat);
        reg_addr = 2'd3; #1;
        chk({tag, " vector"}, int'(reg_rdata), evec);
        chk({tag, " irq"}, int'(irq), eirq);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        peek_all("R1 reset", 0, 0, 0, 0);
        reg_addr = 2'd2; #1;
        chk("R1 reset enable", int'(reg_rdata), 0);

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            reg_wr = ROWS[i].wr; reg_rd = ROWS[i].rd; reg_addr = ROWS[i].addr;
            reg_wdata = ROWS[i].wdata;
            {ev_ack, ev_nack, ev_arb_lost, ev_start_req} = ROWS[i].ev;
            bus_busy = ROWS[i].busy; gen_call = ROWS[i].gcall;
            @(negedge clk);
            idle();
            peek_all($sformatf("R%0d row %0d", ROWS[i].req, i),
                     int'(ROWS[i].emode), int'(ROWS[i].estat),
                     int'(ROWS[i].evec), int'(ROWS[i].eirq));
        end

        // R1 again: system reset in the middle of activity with a flag pending
        @(negedge clk);
        ev_nack = 1'b1;
        @(negedge clk);
        idle();
        peek_all("R1 pre-reset", 5, 2, 2, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        peek_all("R1 mid reset", 0, 0, 0, 0);
        reg_addr = 2'd2; #1;
        chk("R1 mid reset enable", int'(reg_rdata), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule